// File: doc/BRIEF.md
# Interrupt Status Raise/Acknowledge Controller

This block keeps a 32-bit word of pending interrupt causes and turns it into an interrupt request toward the host. Causes arrive from two sources. Internal completion pulses each set one fixed bit: one for a finished computation and one for a finished data transfer. Software can also set any bits by writing a mask to a raise strobe. Software clears bits by writing a mask to an acknowledge strobe. The bus decode outside the block reduces each register access to a one-cycle write strobe with its data. The pending word is presented on an output port, and that port is what a status read returns.

A mode input selects how the request is delivered. In level mode, an interrupt line is set by any raise that leaves the word nonzero. The line stays high until an acknowledge empties the word. In message mode, the block issues a one-cycle notification pulse for every raise event that leaves the word nonzero. The line is never driven low in that mode, so an acknowledge cannot lower it. Formatting of the message itself is done elsewhere.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the pending word is 0, the interrupt line is 0 and the notification pulse is 0.
- R2: A software raise ORs its mask into the pending word, which updates on the next clock edge; bits already set stay set.
- R3: A software acknowledge clears exactly the bits of its mask in the pending word; other bits are unchanged.
- R4: A computation-done pulse sets bit 0 (mask 0x00000001) and a transfer-done pulse sets bit 8 (mask 0x00000100).
- R5: In level mode (msg_mode = 0), a raise event that leaves the word nonzero sets the interrupt line on the next edge. A raise event is a software raise strobe or any source pulse.
- R6: In level mode, an acknowledge lowers the line only if it leaves the word zero; otherwise the line keeps its value.
- R7: In message mode (msg_mode = 1), every raise event that leaves the word nonzero gives a notification pulse exactly one cycle long, even if the word was already nonzero. A raise in this mode does not change the line.
- R8: In message mode, an acknowledge never lowers the interrupt line, even when it empties the word.
- R9: If a raise and an acknowledge name the same bit in one cycle, the bit ends up set.
- R10: A raise event that leaves the word zero produces no pulse and does not set the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_mode | input | 1 | 1 = message-pulse delivery, 0 = level line |
| src_done | input | 2 | Source completion pulses: [0] computation, [1] transfer |
| raise_we | input | 1 | Software raise strobe |
| raise_mask | input | 32 | Bits to set |
| ack_we | input | 1 | Software acknowledge strobe |
| ack_mask | input | 32 | Bits to clear |
| pend | output | 32 | Current pending word |
| irq_line | output | 1 | Level interrupt request |
| irq_pulse | output | 1 | One-cycle notification pulse |

## Verification
The bound checker verifies on every cycle that:
- raised bits are present after the edge, even when an acknowledge hits the same bit;
- acknowledged bits are gone when nothing re-raises them;
- no bit appears without a raise event;
- the line falls only in level mode and only with an empty word;
- a pulse never stands with an empty word and never lasts two cycles.

Only the bench scenarios can show the following: the fixed bit positions of the two sources, a pulse for a raise that adds no new bit, the line surviving an emptying acknowledge in message mode, and the exact reset values.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    // Delivery state held by the output stage.
    typedef struct packed {
        logic line;
        logic pulse;
    } dlv_t;

    // Width of one source bit-position field in the position vector.
    localparam int POS_FIELD_W = 8;

endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge
    import irq_pend_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int NSRC = 2,
    parameter logic [NSRC*POS_FIELD_W-1:0] SRC_POS = {8'd8, 8'd0}
) (
    input  logic [NSRC-1:0]   src_done,
    input  logic              raise_we,
    input  logic [STAT_W-1:0] raise_mask,
    output logic [STAT_W-1:0] raise_vec,
    output logic              raise_evt
);

    logic [STAT_W-1:0] src_part [NSRC];

    // One fixed status bit per hardware source.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign src_part[i] = src_done[i]
            ? (STAT_W'(1) << SRC_POS[i*POS_FIELD_W +: POS_FIELD_W])
            : '0;
    end

    always_comb begin
        raise_vec = raise_we ? raise_mask : '0;
        for (int i = 0; i < NSRC; i++) begin
            raise_vec = raise_vec | src_part[i];
        end
        raise_evt = raise_we | (|src_done);
    end

endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core #(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] raise_vec,
    input  logic              ack_we,
    input  logic [STAT_W-1:0] ack_mask,
    output logic [STAT_W-1:0] stat_q_o,
    output logic              nz_next
);

    typedef struct packed {
        logic [STAT_W-1:0] stat;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Clear first, then set: a raise beats an acknowledge on the same bit.
        if (ack_we) begin
            st_d.stat = st_d.stat & ~ack_mask;
        end
        st_d.stat = st_d.stat | raise_vec;
        nz_next   = |st_d.stat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q_o = st_q.stat;

endmodule

// File: rtl/irq_pend_deliver.sv
module irq_pend_deliver
    import irq_pend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic msg_mode,
    input  logic raise_evt,
    input  logic ack_we,
    input  logic nz_next,
    output logic line_o,
    output logic pulse_o
);

    dlv_t dv_d, dv_q;

    always_comb begin
        dv_d       = dv_q;
        dv_d.pulse = 1'b0;
        if (raise_evt && nz_next) begin
            if (msg_mode) begin
                dv_d.pulse = 1'b1;
            end else begin
                dv_d.line = 1'b1;
            end
        end else if (ack_we && !nz_next && !msg_mode) begin
            dv_d.line = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q <= '0;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign line_o  = dv_q.line;
    assign pulse_o = dv_q.pulse;

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pend_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int NSRC = 2,
    parameter logic [NSRC*POS_FIELD_W-1:0] SRC_POS = {8'd8, 8'd0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_mode,
    input  logic [NSRC-1:0]   src_done,
    input  logic              raise_we,
    input  logic [STAT_W-1:0] raise_mask,
    input  logic              ack_we,
    input  logic [STAT_W-1:0] ack_mask,
    output logic [STAT_W-1:0] pend,
    output logic              irq_line,
    output logic              irq_pulse
);

    logic [STAT_W-1:0] raise_vec;
    logic              raise_evt;
    logic              nz_next;

    irq_pend_merge #(
        .STAT_W (STAT_W),
        .NSRC   (NSRC),
        .SRC_POS(SRC_POS)
    ) u_merge (
        .src_done  (src_done),
        .raise_we  (raise_we),
        .raise_mask(raise_mask),
        .raise_vec (raise_vec),
        .raise_evt (raise_evt)
    );

    irq_pend_core #(
        .STAT_W(STAT_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise_vec(raise_vec),
        .ack_we   (ack_we),
        .ack_mask (ack_mask),
        .stat_q_o (pend),
        .nz_next  (nz_next)
    );

    irq_pend_deliver u_dlv (
        .clk      (clk),
        .rst_n    (rst_n),
        .msg_mode (msg_mode),
        .raise_evt(raise_evt),
        .ack_we   (ack_we),
        .nz_next  (nz_next),
        .line_o   (irq_line),
        .pulse_o  (irq_pulse)
    );

endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
    parameter int STAT_W = 32,
    parameter int NSRC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msg_mode,
    input logic [NSRC-1:0]   src_done,
    input logic              raise_we,
    input logic [STAT_W-1:0] raise_mask,
    input logic              ack_we,
    input logic [STAT_W-1:0] ack_mask,
    input logic [STAT_W-1:0] pend,
    input logic              irq_line,
    input logic              irq_pulse
);

    // Raised bits are present after the edge; this also covers same-cycle acknowledges.
    assert_raise_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        raise_we |=> ((pend & $past(raise_mask)) == $past(raise_mask)));

    // Acknowledged bits are gone when nothing raises in that cycle.
    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !raise_we && src_done == '0) |=> ((pend & $past(ack_mask)) == '0));

    // A bit can only appear through a raise event.
    assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!raise_we && src_done == '0) |=> ((pend & ~$past(pend)) == '0));

    // The line falls only in level mode.
    assert_line_hold_msg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_mode && irq_line) |=> irq_line);

    // The line falls only when the word is empty.
    assert_line_fall_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_line) |-> (pend == '0));

    // A pulse never stands with an empty word.
    assert_pulse_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (pend != '0));

    // Without a raise event the next cycle carries no pulse.
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!raise_we && src_done == '0) |=> !irq_pulse);

endmodule

bind irq_pend_ctrl irq_pend_chk #(.STAT_W(STAT_W), .NSRC(NSRC)) u_chk (.*);

// File: tb/sim_irq_pend_ctrl.sv
module sim_irq_pend_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_mode = 1'b0;
    logic [1:0]  src_done = '0;
    logic        raise_we = 1'b0;
    logic [31:0] raise_mask = '0;
    logic        ack_we = 1'b0;
    logic [31:0] ack_mask = '0;
    logic [31:0] pend;
    logic        irq_line;
    logic        irq_pulse;

    always #10 clk = ~clk;   // 50 MHz

    irq_pend_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .src_done(src_done),
        .raise_we(raise_we), .raise_mask(raise_mask),
        .ack_we(ack_we), .ack_mask(ack_mask),
        .pend(pend), .irq_line(irq_line), .irq_pulse(irq_pulse)
    );

    typedef struct {
        logic [31:0] stat;
        logic        line;
        logic        pulse;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;
    logic [31:0] m_stat = '0;
    logic        m_line = 1'b0;

    task automatic check(input string tag, input logic [31:0] act_s, input logic act_l,
                         input logic act_p, input logic [31:0] e_s, input logic e_l,
                         input logic e_p);
        n_chk++;
        if (act_s !== e_s || act_l !== e_l || act_p !== e_p) begin
            n_fail++;
            $display("FAIL %s: pend=%h line=%b pulse=%b expected pend=%h line=%b pulse=%b",
                     tag, act_s, act_l, act_p, e_s, e_l, e_p);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outcome.
    task automatic step(input string tag, input logic mode, input logic [1:0] src,
                        input logic rw, input logic [31:0] rm,
                        input logic aw, input logic [31:0] am);
        exp_t e;
        logic evt;
        @(negedge clk);
        msg_mode = mode; src_done = src;
        raise_we = rw; raise_mask = rm; ack_we = aw; ack_mask = am;
        if (aw) m_stat = m_stat & ~am;
        if (rw) m_stat = m_stat | rm;
        if (src[0]) m_stat = m_stat | 32'h0000_0001;
        if (src[1]) m_stat = m_stat | 32'h0000_0100;
        evt = rw || (src != 2'b00);
        e.pulse = 1'b0;
        if (evt && m_stat != 0) begin
            if (mode) e.pulse = 1'b1;
            else m_line = 1'b1;
        end else if (aw && m_stat == 0 && !mode) begin
            m_line = 1'b0;
        end
        e.stat = m_stat; e.line = m_line; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares after each edge against the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, pend, irq_line, irq_pulse, e.stat, e.line, e.pulse);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // Hold a raise during reset: reset must dominate.
        raise_we = 1'b1; raise_mask = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #2 check("R1 in reset", pend, irq_line, irq_pulse, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        raise_we = 1'b0; raise_mask = '0;
        rst_n = 1'b1;
        @(posedge clk);
        #2 check("R1 after reset", pend, irq_line, irq_pulse, 32'h0, 1'b0, 1'b0);

        step("R2 R5 raise F0",        0, 2'b00, 1, 32'h0000_00F0, 0, 32'h0);
        step("R2 idle hold",          0, 2'b00, 0, 32'h0,         0, 32'h0);
        step("R2 OR in 3",            0, 2'b00, 1, 32'h0000_0003, 0, 32'h0);
        step("R3 R6 ack 0F partial",  0, 2'b00, 0, 32'h0,         1, 32'h0000_000F);
        step("R6 ack F0 empties",     0, 2'b00, 0, 32'h0,         1, 32'h0000_00F0);
        step("R4 computation bit0",   0, 2'b01, 0, 32'h0,         0, 32'h0);
        step("R4 transfer bit8",      0, 2'b10, 0, 32'h0,         0, 32'h0);
        step("R3 ack both",           0, 2'b00, 0, 32'h0,         1, 32'h0000_0101);
        step("R9 raise and ack bit2", 0, 2'b00, 1, 32'h0000_0004, 1, 32'h0000_0004);
        step("R9 ack bit2",           0, 2'b00, 0, 32'h0,         1, 32'h0000_0004);
        step("R10 zero raise level",  0, 2'b00, 1, 32'h0,         0, 32'h0);
        step("R7 msg raise 10",       1, 2'b00, 1, 32'h0000_0010, 0, 32'h0);
        step("R7 pulse one cycle",    1, 2'b00, 0, 32'h0,         0, 32'h0);
        step("R7 pulse no new bit",   1, 2'b00, 1, 32'h0,         0, 32'h0);
        step("R7 msg ack empties",    1, 2'b00, 0, 32'h0,         1, 32'h0000_0010);
        step("R10 zero raise msg",    1, 2'b00, 1, 32'h0,         0, 32'h0);
        step("R5 level raise 200",    0, 2'b00, 1, 32'h0000_0200, 0, 32'h0);
        step("R8 msg ack keeps line", 1, 2'b00, 0, 32'h0,         1, 32'h0000_0200);
        step("R4 R7 msg source",      1, 2'b01, 0, 32'h0,         0, 32'h0);
        step("R6 level ack lowers",   0, 2'b00, 0, 32'h0,         1, 32'h0000_0001);
        step("R5 both sources",       0, 2'b11, 0, 32'h0,         0, 32'h0);
        step("R9 src vs ack bit8",    0, 2'b10, 0, 32'h0,         1, 32'hFFFF_FFFF);
        step("R6 idle end",           0, 2'b00, 0, 32'h0,         0, 32'h0);
        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule